// File: doc/BRIEF.md
# Level-Sensitive Interrupt Take Decision and Mode Router

This block sits between the two active-low interrupt request pins of a processor core (a fast line and a normal line) and the exception-entry sequencer. Each pin is first captured in a flip-flop. Only the registered level takes part in any decision. When the pipeline signals that an instruction has completed, the block checks the captured levels against the status-word mask bits and the security configuration. It then emits at most one registered take pulse for that boundary.

The fast line always wins over the normal line. A configuration bit can make the fast mask ineffective while the core runs in the non-secure world. Two further bits choose whether each interrupt is handled in its own local mode or in the secure monitor mode. With every take pulse the block also raises mask-set strobes, which the entry logic uses to update the status word: a fast take masks both lines, and a normal take masks the normal line.

Top module: `intr_take_router`

## Requirements
- R1: Each pin passes through one register stage. A pin level present at clock edge N first affects a decision at edge N+1, and the resulting take pulse is visible from edge N+1 until edge N+2.
- R2: Requests are level-sensitive. A pin held low keeps producing a take pulse at every boundary for as long as its line stays unmasked.
- R3: Take pulses appear only in the cycle after a cycle where `insn_done` was high, and each lasts one cycle. Nothing is taken while `insn_done` is low.
- R4: A high `mask_f` blocks the fast line, and a high `mask_i` blocks the normal line.
- R5: When both lines are eligible at one boundary, only `take_fiq` is asserted.
- R6: When `cfg_fiq_nomask_ns` and `nonsec` are both high, `mask_f` has no effect. With `nonsec` low, `mask_f` blocks as in R4.
- R7: `tgt_mode` encodes the handler mode: 0 = no take, 1 = local fast mode, 2 = local normal mode, 3 = monitor. A fast take yields 3 when `cfg_fiq_mon` is high, otherwise 1. A normal take yields 3 when `cfg_irq_mon` is high, otherwise 2.
- R8: With a fast take, both `set_mask_f` and `set_mask_i` are high. With a normal take, only `set_mask_i` is high. Both are low otherwise.
- R9: While `rst_n` is low, all outputs are 0 and both sample registers hold the inactive (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_n | input | 1 | Fast interrupt request pin, active low |
| irq_n | input | 1 | Normal interrupt request pin, active low |
| insn_done | input | 1 | Instruction-boundary strobe |
| mask_f | input | 1 | Status-word fast mask |
| mask_i | input | 1 | Status-word normal mask |
| nonsec | input | 1 | Core is in the non-secure world |
| cfg_fiq_nomask_ns | input | 1 | Fast mask ignored in the non-secure world |
| cfg_fiq_mon | input | 1 | Route fast interrupt to monitor mode |
| cfg_irq_mon | input | 1 | Route normal interrupt to monitor mode |
| take_fiq | output | 1 | Fast interrupt taken (one-cycle pulse) |
| take_irq | output | 1 | Normal interrupt taken (one-cycle pulse) |
| set_mask_f | output | 1 | Request to set the fast mask |
| set_mask_i | output | 1 | Request to set the normal mask |
| tgt_mode | output | 2 | Handler mode code, see R7 |

## Verification
Two functions can fall in the same cycle: the priority choice between the lines, and the non-secure override of the fast mask. When the override revives a masked fast request while the normal line is also pending, the fast line must still win. The bench provokes this directly: it holds both pins low with `mask_f` set, toggles `nonsec` across boundaries, and expects the taken line to flip between normal and fast. A random phase then sweeps all input combinations against a behavioural reference model that is compared on every clock.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_FIQ  = 0;
    localparam int unsigned LINE_IRQ  = 1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_FIQ  = 2'd1,
        TGT_IRQ  = 2'd2,
        TGT_MON  = 2'd3
    } tgt_mode_e;

    typedef struct packed {
        logic      take_fiq;
        logic      take_irq;
        logic      set_f;
        logic      set_i;
        tgt_mode_e mode;
    } decision_t;

    localparam decision_t DECISION_IDLE = '{
        take_fiq: 1'b0,
        take_irq: 1'b0,
        set_f:    1'b0,
        set_i:    1'b0,
        mode:     TGT_NONE
    };

endpackage

// File: rtl/intr_pin_sampler.sv
module intr_pin_sampler #(
    parameter int unsigned N_LINES = 2,
    parameter int unsigned STAGES  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pins_n,
    output logic [N_LINES-1:0] sampled_n
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][N_LINES-1:0] stg_d;
    logic [STAGES-1:0][N_LINES-1:0] stg_q;

    // R1: pins are captured before any decision logic sees them
    always_comb begin
        stg_d[0] = pins_n;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    // R9: inactive level (high) on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sampled_n = stg_q[LAST];

    generate
        if (STAGES == 1) begin : g_single
            p_sample_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (sampled_n == $past(pins_n)))
                else $error("R1 sample register does not follow pins by one cycle");
        end
    endgenerate

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_route_pkg::*;
(
    input  logic [NUM_LINES-1:0] sampled_n,
    input  logic                 boundary,
    input  logic                 mask_f,
    input  logic                 mask_i,
    input  logic                 nonsec,
    input  logic                 cfg_fiq_nomask_ns,
    input  logic                 cfg_fiq_mon,
    input  logic                 cfg_irq_mon,
    output decision_t            dec_d
);

    logic fiq_req;
    logic irq_req;
    logic fiq_blocked;
    logic fiq_ok;
    logic irq_ok;

    always_comb begin
        fiq_req = ~sampled_n[LINE_FIQ];
        irq_req = ~sampled_n[LINE_IRQ];

        // R6: the non-secure override defeats the fast mask
        fiq_blocked = mask_f & ~(cfg_fiq_nomask_ns & nonsec);

        // R4: per-line masks
        fiq_ok = fiq_req & ~fiq_blocked;
        irq_ok = irq_req & ~mask_i;

        dec_d = DECISION_IDLE;
        // R3: decisions only at boundaries; R5: fast line first
        if (boundary) begin
            if (fiq_ok) begin
                dec_d.take_fiq = 1'b1;
                dec_d.set_f    = 1'b1;   // R8
                dec_d.set_i    = 1'b1;
                dec_d.mode     = cfg_fiq_mon ? TGT_MON : TGT_FIQ;  // R7
            end else if (irq_ok) begin
                dec_d.take_irq = 1'b1;
                dec_d.set_i    = 1'b1;   // R8
                dec_d.mode     = cfg_irq_mon ? TGT_MON : TGT_IRQ;  // R7
            end
        end
    end

endmodule

// File: rtl/intr_take_reg.sv
module intr_take_reg
    import intr_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  decision_t dec_d,
    output decision_t dec_q
);

    decision_t out_d;
    decision_t out_q;

    always_comb begin
        out_d = dec_d;
    end

    // R9: idle decision under reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= DECISION_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_q = out_q;

    p_single_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_q.take_fiq, out_q.take_irq}))
        else $error("R5 both lines taken at once");

    p_mode_matches_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.take_fiq || out_q.take_irq) == (out_q.mode != TGT_NONE))
        else $error("R7 mode code disagrees with take pulses");

endmodule

// File: rtl/intr_take_router.sv
module intr_take_router
    import intr_route_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fiq_n,
    input  logic       irq_n,
    input  logic       insn_done,
    input  logic       mask_f,
    input  logic       mask_i,
    input  logic       nonsec,
    input  logic       cfg_fiq_nomask_ns,
    input  logic       cfg_fiq_mon,
    input  logic       cfg_irq_mon,
    output logic       take_fiq,
    output logic       take_irq,
    output logic       set_mask_f,
    output logic       set_mask_i,
    output logic [1:0] tgt_mode
);

    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] sampled_n;
    decision_t            dec_d;
    decision_t            dec_q;

    always_comb begin
        pins_n           = '1;
        pins_n[LINE_FIQ] = fiq_n;
        pins_n[LINE_IRQ] = irq_n;
    end

    intr_pin_sampler #(
        .N_LINES (NUM_LINES),
        .STAGES  (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_n    (pins_n),
        .sampled_n (sampled_n)
    );

    intr_arbiter u_arb (
        .sampled_n         (sampled_n),
        .boundary          (insn_done),
        .mask_f            (mask_f),
        .mask_i            (mask_i),
        .nonsec            (nonsec),
        .cfg_fiq_nomask_ns (cfg_fiq_nomask_ns),
        .cfg_fiq_mon       (cfg_fiq_mon),
        .cfg_irq_mon       (cfg_irq_mon),
        .dec_d             (dec_d)
    );

    intr_take_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_d (dec_d),
        .dec_q (dec_q)
    );

    assign take_fiq   = dec_q.take_fiq;
    assign take_irq   = dec_q.take_irq;
    assign set_mask_f = dec_q.set_f;
    assign set_mask_i = dec_q.set_i;
    assign tgt_mode   = dec_q.mode;

    p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_fiq || take_irq) |-> $past(insn_done))
        else $error("R3 take without a boundary");

    p_fmask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq |-> (!$past(mask_f) || ($past(cfg_fiq_nomask_ns) && $past(nonsec))))
        else $error("R4 fast take while masked");

    p_imask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !$past(mask_i))
        else $error("R4 normal take while masked");

    p_fiq_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq |-> (tgt_mode == ($past(cfg_fiq_mon) ? 2'd3 : 2'd1)))
        else $error("R7 fast route wrong");

    p_fiq_sets_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq |-> (set_mask_f && set_mask_i))
        else $error("R8 fast take must set both masks");

    p_irq_sets_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (!set_mask_f && set_mask_i))
        else $error("R8 normal take must set only the normal mask");

endmodule

// File: tb/intr_take_router_test.sv
`timescale 1ns/1ps
module intr_take_router_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fiq_n = 1'b1, irq_n = 1'b1, insn_done = 1'b0;
    logic       mask_f = 1'b0, mask_i = 1'b0, nonsec = 1'b0;
    logic       cfg_fw = 1'b0, cfg_fm = 1'b0, cfg_im = 1'b0;
    logic       take_fiq, take_irq, set_mask_f, set_mask_i;
    logic [1:0] tgt_mode;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic       m_f = 1'b1, m_i = 1'b1;
    logic       e_tf = 1'b0, e_ti = 1'b0, e_sf = 1'b0, e_si = 1'b0;
    logic [1:0] e_mode = 2'd0;

    always #2.5 clk = ~clk;

    intr_take_router uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .fiq_n             (fiq_n),
        .irq_n             (irq_n),
        .insn_done         (insn_done),
        .mask_f            (mask_f),
        .mask_i            (mask_i),
        .nonsec            (nonsec),
        .cfg_fiq_nomask_ns (cfg_fw),
        .cfg_fiq_mon       (cfg_fm),
        .cfg_irq_mon       (cfg_im),
        .take_fiq          (take_fiq),
        .take_irq          (take_irq),
        .set_mask_f        (set_mask_f),
        .set_mask_i        (set_mask_i),
        .tgt_mode          (tgt_mode)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: registered samples, decision at each edge
    always @(posedge clk) begin
        logic f_ok, i_ok;
        if (!rst_n) begin
            m_f = 1'b1; m_i = 1'b1;
            e_tf = 0; e_ti = 0; e_sf = 0; e_si = 0; e_mode = 0;
        end else begin
            f_ok = !m_f && (!mask_f || (cfg_fw && nonsec));
            i_ok = !m_i && !mask_i;
            e_tf = insn_done && f_ok;
            e_ti = insn_done && i_ok && !f_ok;
            e_sf = e_tf;
            e_si = e_tf || e_ti;
            e_mode = e_tf ? (cfg_fm ? 2'd3 : 2'd1) : (e_ti ? (cfg_im ? 2'd3 : 2'd2) : 2'd0);
            m_f = fiq_n;
            m_i = irq_n;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        chk(take_fiq == e_tf, "R3 R5 model take_fiq", take_fiq, e_tf);
        chk(take_irq == e_ti, "R3 R4 model take_irq", take_irq, e_ti);
        chk(set_mask_f == e_sf, "R8 model set_mask_f", set_mask_f, e_sf);
        chk(set_mask_i == e_si, "R8 model set_mask_i", set_mask_i, e_si);
        chk(tgt_mode == e_mode, "R7 model tgt_mode", tgt_mode, e_mode);
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_pins();
        fiq_n = 1'b1; irq_n = 1'b1; insn_done = 1'b0;
        tick(); tick();
    endtask

    // raise the boundary for one cycle; outputs then hold that decision
    task automatic boundary();
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
    endtask

    initial begin
        // R9: reset state
        tick(); tick();
        fiq_n = 1'b0; irq_n = 1'b0; insn_done = 1'b1;
        tick();
        chk(!take_fiq && !take_irq && tgt_mode == 2'd0 && !set_mask_f && !set_mask_i,
            "R9 outputs idle in reset", {take_fiq, take_irq, tgt_mode}, 0);
        fiq_n = 1'b1; irq_n = 1'b1; insn_done = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        boundary();
        chk(!take_fiq && !take_irq, "R9 samples inactive after reset", {take_fiq, take_irq}, 0);

        // R1: pin and boundary together -> not yet; next boundary -> taken
        idle_pins();
        fiq_n = 1'b0; insn_done = 1'b1;
        tick();
        chk(take_fiq == 1'b0, "R1 no take before sample", take_fiq, 0);
        tick();
        chk(take_fiq == 1'b1, "R1 take one cycle after sample", take_fiq, 1);
        insn_done = 1'b0;

        // R3: no boundary, nothing taken
        idle_pins();
        fiq_n = 1'b0; irq_n = 1'b0;
        repeat (4) tick();
        chk(!take_fiq && !take_irq, "R3 no take without boundary", {take_fiq, take_irq}, 0);

        // R2: level keeps requesting at each boundary
        irq_n = 1'b1;
        boundary();
        chk(take_fiq == 1'b1, "R2 first boundary", take_fiq, 1);
        tick();
        chk(take_fiq == 1'b0, "R3 pulse is one cycle", take_fiq, 0);
        boundary();
        chk(take_fiq == 1'b1, "R2 second boundary", take_fiq, 1);

        // R4: masks
        mask_f = 1'b1;
        boundary();
        chk(take_fiq == 1'b0, "R4 fast masked", take_fiq, 0);
        idle_pins();
        irq_n = 1'b0; mask_i = 1'b1; tick();
        boundary();
        chk(take_irq == 1'b0, "R4 normal masked", take_irq, 0);
        mask_i = 1'b0;
        boundary();
        chk(take_irq == 1'b1 && tgt_mode == 2'd2, "R4 normal unmasked local mode",
            {take_irq, tgt_mode}, 6);
        chk(set_mask_i && !set_mask_f, "R8 normal sets only I", {set_mask_f, set_mask_i}, 1);

        // R5 + R6 in the same cycle: both pending, fast masked, toggle world
        fiq_n = 1'b0; cfg_fw = 1'b1; nonsec = 1'b0; tick();
        boundary();
        chk(take_irq == 1'b1 && take_fiq == 1'b0, "R6 secure: mask holds, normal wins",
            {take_fiq, take_irq}, 1);
        nonsec = 1'b1;
        boundary();
        chk(take_fiq == 1'b1 && take_irq == 1'b0, "R5 R6 non-secure override, fast wins",
            {take_fiq, take_irq}, 2);
        chk(set_mask_f && set_mask_i, "R8 fast sets both", {set_mask_f, set_mask_i}, 3);
        cfg_fw = 1'b0;
        boundary();
        chk(take_fiq == 1'b0, "R6 override off, mask holds", take_fiq, 0);

        // R7: routing
        mask_f = 1'b0; cfg_fm = 1'b1;
        boundary();
        chk(take_fiq && tgt_mode == 2'd3, "R7 fast to monitor", tgt_mode, 3);
        cfg_fm = 1'b0;
        boundary();
        chk(tgt_mode == 2'd1, "R7 fast local", tgt_mode, 1);
        fiq_n = 1'b1; cfg_im = 1'b1; tick();
        boundary();
        chk(take_irq && tgt_mode == 2'd3, "R7 normal to monitor", tgt_mode, 3);
        cfg_im = 1'b0; nonsec = 1'b0;
        idle_pins();

        // random sweep against the model
        for (int k = 0; k < 4000; k++) begin
            fiq_n     = ($urandom_range(0, 2) != 0);
            irq_n     = ($urandom_range(0, 2) != 0);
            insn_done = $urandom_range(0, 1);
            mask_f    = $urandom_range(0, 1);
            mask_i    = $urandom_range(0, 1);
            nonsec    = $urandom_range(0, 1);
            cfg_fw    = $urandom_range(0, 1);
            cfg_fm    = $urandom_range(0, 1);
            cfg_im    = $urandom_range(0, 1);
            tick();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule